// File: doc/BRIEF.md
# Chained Microsecond Timestamp Counter

This block keeps a 32-bit free-running time value made of two 16-bit up-counters. The lower half advances once per prescaled period, so a divide ratio of (input clock in MHz − 1) gives microsecond steps. The upper half advances once each time the lower half rolls over from all-ones to zero. Software controls the block through a small 16-bit register bus and receives one interrupt line.

Software sets a one-shot alarm by writing the upper deadline half and then the lower half. The second write commits the alarm. If the deadline lies in a later upper-half epoch, the upper compare is armed. When the upper compare hits, it passes control to the lower compare on its own. If the deadline lies in the current epoch, the lower compare is armed directly. A deadline already in the past arms nothing.

A read of the low count takes a copy of the high count at the same time, so a two-read 32-bit sample cannot tear across a rollover. Each count half can be rewritten only while that half is stopped.

Top module: `usec_timebase`

## Requirements
- R1: While low counting is enabled (CTRL, address 0, bit 0), the low count (address 2) advances once every P+1 clocks, where P is the active divide value. P is written at address 1.
- R2: A divide value written at address 1 becomes active only when the low count rolls over, or at once when CTRL is written with bit 2 set. The bit-2 write also restarts the divide phase.
- R3: With high counting enabled (CTRL bit 1), the high count advances by exactly one on each low rollover from 0xFFFF to 0x0000. Each half wraps to zero after all-ones.
- R4: A high-count rollover from 0xFFFF to 0x0000 sets STATUS (address 6) bit 0.
- R5: A write to address 5 commits a deadline. Its upper half is the value last written at address 4. If that upper half exceeds the high count, only the upper compare is armed (address 7 read bit 2) and STATUS bits 1 and 2 clear.
- R6: At commit, suppose the upper half equals the high count and the lower half exceeds the low count. Then only the lower compare is armed (address 7 read bit 3) and STATUS bits 1 and 2 clear. Any other deadline arms neither compare and leaves STATUS unchanged.
- R7: An upper-compare hit sets STATUS bit 1 and arms the lower compare with the stored lower half. When that lower half is zero, STATUS bit 2 is set in the same cycle instead.
- R8: A lower-compare hit sets STATUS bit 2 on the clock edge where the low count reaches the compare value.
- R9: irq is the registered OR of (STATUS bit 0 AND enable bit 0) and (STATUS bit 2 AND enable bit 1). The enables are written at address 7, bits 1:0. irq follows STATUS by one clock.
- R10: A read returns data on the clock after reg_rd. A read of address 2 copies the high count into a shadow, and reads of address 3 return that shadow.
- R11: A write at address 2 or 3 loads the low or high count only while that half is stopped. Otherwise the write is ignored.
- R12: STATUS bits are write-zero-to-clear: each written 0 clears its bit and each written 1 leaves it unchanged.
- R13: After reset all counts, STATUS, enables, CTRL and irq are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | HALF_W | Write data |
| reg_rdata | output | HALF_W | Read data, valid the clock after reg_rd |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a count half is loaded only while it is stopped. They also assume a deadline commit does not land on the same edge as a compare hit, and that the divide value changes only through its register. The stimulus keeps to these by loading timestamps and committing deadlines with both halves stopped. It starts counting only after the alarm state has been read back, and it stops the counters before it inspects counts or STATUS. Timing checks count every edge from the CTRL write that starts counting, including the edge on which the stopping write lands.

// File: rtl/ubase_pkg.sv
`timescale 1ns/1ps
package ubase_pkg;
  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_DIV   = 3'd1,
    A_TSLO  = 3'd2,
    A_TSHI  = 3'd3,
    A_DLHI  = 3'd4,
    A_DLLO  = 3'd5,
    A_STAT  = 3'd6,
    A_IEN   = 3'd7
  } reg_addr_e;

  localparam int ST_OVF    = 0;
  localparam int ST_HMATCH = 1;
  localparam int ST_LMATCH = 2;
  localparam int ST_W      = 3;
endpackage

// File: rtl/ubase_prescale.sv
`timescale 1ns/1ps
module ubase_prescale #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         upd,
  input  logic [W-1:0] div_in,
  output logic         tick
);
  logic [W-1:0] phase;
  logic [W-1:0] div_act;

  assign tick = run && (phase == div_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      div_act <= '0;
    end else if (upd) begin
      div_act <= div_in;
      phase   <= '0;
    end else if (run) begin
      phase <= tick ? '0 : phase + 1'b1;
    end
  end

  // R1: after a tick with a nonzero divide and no update, the next cycle cannot tick
  a_r1_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (tick && div_act != '0 && !upd) |=> !tick);
endmodule

// File: rtl/ubase_half.sv
`timescale 1ns/1ps
module ubase_half #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic [W-1:0] nxt,
  output logic         wrap
);
  assign nxt  = cnt + 1'b1;
  assign wrap = inc && (&cnt);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (inc) cnt <= nxt;
  end

  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && (&cnt)) |=> (cnt == '0));
endmodule

// File: rtl/ubase_match.sv
`timescale 1ns/1ps
module ubase_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         commit,
  input  logic [W-1:0] dl_hi,
  input  logic [W-1:0] dl_lo,
  input  logic [W-1:0] cnt_hi,
  input  logic [W-1:0] cnt_lo,
  input  logic         hi_inc,
  input  logic [W-1:0] hi_nxt,
  input  logic         lo_inc,
  input  logic [W-1:0] lo_nxt,
  output logic         arm_hi,
  output logic         arm_lo,
  output logic         hi_hit,
  output logic         lo_hit,
  output logic         clr_flags
);
  logic [W-1:0] cmp_hi;
  logic [W-1:0] cmp_lo;
  logic         later_epoch;
  logic         this_epoch;

  assign later_epoch = dl_hi > cnt_hi;
  assign this_epoch  = (dl_hi == cnt_hi) && (dl_lo > cnt_lo);
  assign clr_flags   = commit && (later_epoch || this_epoch);

  assign hi_hit = arm_hi && hi_inc && (hi_nxt == cmp_hi);
  assign lo_hit = (arm_lo && lo_inc && (lo_nxt == cmp_lo)) ||
                  (hi_hit && (cmp_lo == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_hi <= '0;
      cmp_lo <= '0;
      arm_hi <= 1'b0;
      arm_lo <= 1'b0;
    end else if (commit) begin
      cmp_hi <= dl_hi;
      cmp_lo <= dl_lo;
      arm_hi <= later_epoch;
      arm_lo <= this_epoch;
    end else if (hi_hit) begin
      arm_hi <= 1'b0;
      arm_lo <= (cmp_lo != '0);
    end else if (lo_hit) begin
      arm_lo <= 1'b0;
    end
  end

  // R5/R6: never both compares armed
  a_r5_single_arm: assert property (@(posedge clk) disable iff (rst)
    !(arm_hi && arm_lo));

  // R7: an upper hit with a nonzero lower half hands over to the lower compare
  a_r7_handover: assert property (@(posedge clk) disable iff (rst)
    (hi_hit && !commit && cmp_lo != '0) |=> (arm_lo && !arm_hi));
endmodule

// File: rtl/usec_timebase.sv
`timescale 1ns/1ps
module usec_timebase
  import ubase_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [HALF_W-1:0] reg_wdata,
  output logic [HALF_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int EN_W = 2;

  logic              run_lo, run_hi;
  logic [HALF_W-1:0] div_q;
  logic [HALF_W-1:0] shadow_hi;
  logic [HALF_W-1:0] dl_hi_q, dl_lo_q;
  logic [ST_W-1:0]   status, status_n;
  logic [EN_W-1:0]   ien;

  logic wr_ctrl, wr_div, wr_tslo, wr_tshi, wr_dlhi, wr_dllo, wr_stat, wr_ien;
  logic force_upd;
  logic lo_tick, lo_wrap, hi_inc, hi_wrap;
  logic [HALF_W-1:0] cnt_lo, cnt_hi, lo_nxt, hi_nxt;
  logic arm_hi, arm_lo, hi_hit, lo_hit, clr_flags;

  assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
  assign wr_div    = reg_wr && (reg_addr == A_DIV);
  assign wr_tslo   = reg_wr && (reg_addr == A_TSLO);
  assign wr_tshi   = reg_wr && (reg_addr == A_TSHI);
  assign wr_dlhi   = reg_wr && (reg_addr == A_DLHI);
  assign wr_dllo   = reg_wr && (reg_addr == A_DLLO);
  assign wr_stat   = reg_wr && (reg_addr == A_STAT);
  assign wr_ien    = reg_wr && (reg_addr == A_IEN);
  assign force_upd = wr_ctrl && reg_wdata[2];

  ubase_prescale #(.W(HALF_W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .run    (run_lo),
    .upd    (lo_wrap || force_upd),
    .div_in (div_q),
    .tick   (lo_tick)
  );

  ubase_half #(.W(HALF_W)) u_lo (
    .clk    (clk),
    .rst    (rst),
    .inc    (lo_tick),
    .ld     (wr_tslo && !run_lo),
    .ld_val (reg_wdata),
    .cnt    (cnt_lo),
    .nxt    (lo_nxt),
    .wrap   (lo_wrap)
  );

  assign hi_inc = lo_wrap && run_hi;

  ubase_half #(.W(HALF_W)) u_hi (
    .clk    (clk),
    .rst    (rst),
    .inc    (hi_inc),
    .ld     (wr_tshi && !run_hi),
    .ld_val (reg_wdata),
    .cnt    (cnt_hi),
    .nxt    (hi_nxt),
    .wrap   (hi_wrap)
  );

  ubase_match #(.W(HALF_W)) u_match (
    .clk       (clk),
    .rst       (rst),
    .commit    (wr_dllo),
    .dl_hi     (dl_hi_q),
    .dl_lo     (reg_wdata),
    .cnt_hi    (cnt_hi),
    .cnt_lo    (cnt_lo),
    .hi_inc    (hi_inc),
    .hi_nxt    (hi_nxt),
    .lo_inc    (lo_tick),
    .lo_nxt    (lo_nxt),
    .arm_hi    (arm_hi),
    .arm_lo    (arm_lo),
    .hi_hit    (hi_hit),
    .lo_hit    (lo_hit),
    .clr_flags (clr_flags)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      run_lo  <= 1'b0;
      run_hi  <= 1'b0;
      div_q   <= '0;
      dl_hi_q <= '0;
      dl_lo_q <= '0;
      ien     <= '0;
    end else begin
      if (wr_ctrl) begin
        run_lo <= reg_wdata[0];
        run_hi <= reg_wdata[1];
      end
      if (wr_div)  div_q   <= reg_wdata;
      if (wr_dlhi) dl_hi_q <= reg_wdata;
      if (wr_dllo) dl_lo_q <= reg_wdata;
      if (wr_ien)  ien     <= reg_wdata[EN_W-1:0];
    end
  end

  // status: software clear, arming clear, then hardware set
  always_comb begin
    status_n = status;
    if (wr_stat)   status_n = status_n & reg_wdata[ST_W-1:0];
    if (clr_flags) begin
      status_n[ST_HMATCH] = 1'b0;
      status_n[ST_LMATCH] = 1'b0;
    end
    if (hi_wrap) status_n[ST_OVF]    = 1'b1;
    if (hi_hit)  status_n[ST_HMATCH] = 1'b1;
    if (lo_hit)  status_n[ST_LMATCH] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_n;
      irq    <= (status[ST_OVF] && ien[0]) || (status[ST_LMATCH] && ien[1]);
    end
  end

  // read port with coherent upper half
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      shadow_hi <= '0;
    end else if (reg_rd) begin
      unique case (reg_addr)
        A_CTRL: reg_rdata <= HALF_W'({run_hi, run_lo});
        A_DIV:  reg_rdata <= div_q;
        A_TSLO: begin
          reg_rdata <= cnt_lo;
          shadow_hi <= cnt_hi;
        end
        A_TSHI: reg_rdata <= shadow_hi;
        A_DLHI: reg_rdata <= dl_hi_q;
        A_DLLO: reg_rdata <= dl_lo_q;
        A_STAT: reg_rdata <= HALF_W'(status);
        A_IEN:  reg_rdata <= HALF_W'({arm_lo, arm_hi, ien});
        default: reg_rdata <= '0;
      endcase
    end
  end

  a_r10_shadow_latch: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_TSLO) |=> (shadow_hi == $past(cnt_hi)));

  a_r11_hold_running: assert property (@(posedge clk) disable iff (rst)
    (run_hi && !hi_inc) |=> $stable(cnt_hi));

  a_r12_w0c: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !reg_wdata[ST_OVF] && !hi_wrap) |=> !status[ST_OVF]);

  a_r4_ovf_flag: assert property (@(posedge clk) disable iff (rst)
    hi_wrap |=> status[ST_OVF]);
endmodule

// File: tb/sim_usec_timebase.sv
`timescale 1ns/1ps
module sim_usec_timebase;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  usec_timebase #(.HALF_W(16)) u0 (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  // {timestamp, deadline, expected {arm_lo,arm_hi}, expected status after run}
  localparam int NV = 7;
  localparam logic [68:0] VEC [NV] = '{
    {32'h0001FFF0, 32'h00020005, 2'b01, 3'b110},
    {32'h0001FFF0, 32'h00030000, 2'b01, 3'b000},
    {32'h0001FFF0, 32'h0001FFF8, 2'b10, 3'b100},
    {32'h0001FFF0, 32'h0001FFE0, 2'b00, 3'b100},
    {32'h0001FFF0, 32'h00020000, 2'b01, 3'b110},
    {32'h0001FFF0, 32'h0001FFF0, 2'b00, 3'b110},
    {32'hFFFFFFF0, 32'h00000010, 2'b00, 3'b111}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk);
    #1 reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic load_ts(input logic [31:0] ts);
    wr(3'd3, ts[31:16]);
    wr(3'd2, ts[15:0]);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R13 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic [15:0] v2;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R13 reset state
    rd(3'd0, v); chk("R13 ctrl", v, 0);
    rd(3'd2, v); chk("R13 low count", v, 0);
    rd(3'd3, v); chk("R13 high shadow", v, 0);
    rd(3'd6, v); chk("R13 status", v, 0);
    rd(3'd7, v); chk("R13 enables", v, 0);
    chk("R13 irq", irq, 0);

    // table: arming (R5 R6), handover (R7), low hit (R8), rollover (R3 R4)
    for (int i = 0; i < NV; i++) begin
      load_ts(VEC[i][68:37]);
      wr(3'd4, VEC[i][36:21]);
      wr(3'd5, VEC[i][20:5]);
      rd(3'd7, v);
      chk($sformatf("R5 R6 arm state vec%0d", i), v[3:2], VEC[i][4:3]);
      wr(3'd0, 16'h0003);
      repeat (40) @(posedge clk);
      wr(3'd0, 16'h0000);
      rd(3'd6, v);
      chk($sformatf("R7 R8 R4 status vec%0d", i), v[2:0], VEC[i][2:0]);
    end
    rd(3'd2, v); rd(3'd3, v2);
    chk("R3 high after rollover", {v2, v}, 32'h00000019);

    // R12 write-zero-to-clear
    wr(3'd6, 16'h0007); rd(3'd6, v); chk("R12 ones keep", v, 16'h0007);
    wr(3'd6, 16'h0001); rd(3'd6, v); chk("R12 clear match bits", v, 16'h0001);
    wr(3'd6, 16'h0006); rd(3'd6, v); chk("R12 clear overflow", v, 16'h0000);

    // R9 overflow interrupt
    load_ts(32'hFFFFFFFE);
    wr(3'd7, 16'h0001);
    wr(3'd0, 16'h0003);
    repeat (5) @(posedge clk);
    wr(3'd0, 16'h0000);
    @(negedge clk); chk("R9 irq on overflow", irq, 1);
    wr(3'd6, 16'h0000);
    repeat (2) @(posedge clk);
    @(negedge clk); chk("R9 irq drops after clear", irq, 0);
    wr(3'd7, 16'h0000);

    // R8 exact timing of low hit and irq
    load_ts(32'h00000000);
    wr(3'd7, 16'h0002);
    wr(3'd4, 16'h0000);
    wr(3'd5, 16'h0003);
    wr(3'd0, 16'h0001);
    repeat (3) @(posedge clk);
    @(negedge clk); chk("R8 irq one clock after flag", irq, 0);
    @(posedge clk);
    @(negedge clk); chk("R8 R9 irq asserted", irq, 1);
    wr(3'd0, 16'h0000);
    rd(3'd6, v); chk("R8 low match flag", v, 16'h0004);
    wr(3'd6, 16'h0000);
    wr(3'd7, 16'h0000);

    // R10 coherent read
    load_ts(32'h0007FFFE);
    rd(3'd2, v); chk("R10 low read", v, 16'hFFFE);
    wr(3'd0, 16'h0003);
    repeat (5) @(posedge clk);
    wr(3'd0, 16'h0000);
    rd(3'd3, v); chk("R10 shadow held", v, 16'h0007);
    rd(3'd2, v); chk("R10 low after wrap", v, 16'h0004);
    rd(3'd3, v); chk("R10 shadow refreshed", v, 16'h0008);

    // R11 loads ignored while running
    load_ts(32'h00050000);
    wr(3'd0, 16'h0003);
    wr(3'd3, 16'h00AA);
    wr(3'd2, 16'h1234);
    wr(3'd0, 16'h0000);
    rd(3'd2, v); chk("R11 low not loaded", (v < 16'h0020), 1);
    rd(3'd3, v); chk("R11 high not loaded", v, 16'h0005);

    // R2 deferred divide value
    load_ts(32'h0000FFF8);
    wr(3'd1, 16'h0003);
    wr(3'd0, 16'h0003);
    repeat (19) @(posedge clk);
    wr(3'd0, 16'h0000);
    rd(3'd2, v); rd(3'd3, v2);
    chk("R2 divide applied at rollover", {v2, v}, 32'h00010003);

    // R1 divide by three with forced update
    wr(3'd1, 16'h0002);
    wr(3'd0, 16'h0004);
    load_ts(32'h00000000);
    wr(3'd0, 16'h0001);
    repeat (29) @(posedge clk);
    wr(3'd0, 16'h0000);
    rd(3'd2, v); chk("R1 prescaled count", v, 16'd10);

    finish_run();
  end
endmodule